// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Bank

This block holds a bank of hardware semaphores that several bus masters use to share resources without races. Each semaphore stores a lock flag, the bus master ID of the owner, and an 8-bit process number. A master can claim a semaphore in two ways. In the two-step method it writes a lock request and then reads the entry back to see whether it won. In the one-step method it reads an alias address, and that read both claims a free entry and returns the result.

A release succeeds only when the writer presents the stored owner and process values. A keyed bulk release frees, in one write, every entry held by one master. Each interrupt target core has its own enable, status and clear registers, with one bit per semaphore. A freed semaphore sets the status bit of every core that enabled it.

The register bus carries a word address, write and read strobes, 32-bit write data and a master ID sideband. Read data appears one clock after the read strobe. When both strobes are high in the same cycle, the write is taken and the read is dropped.

Top module: `semBank`

## Requirements
- R1: After reset every semaphore is unlocked with zero owner and process fields, the clear key is zero, every status bit is zero and `irq` is low.
- R2: Each entry register (word address i, 0 to 31) reads back as lock in bit 31, owner ID in bits 11:8 and process in bits 7:0. Read data is valid in the cycle after `busRd`. A write with bit 31 set to a free entry locks it, with owner = `busMaster` and process = write bits 7:0.
- R3: A lock attempt on an entry that is already locked leaves its owner and process unchanged. This covers both a lock write and a one-step read. A one-step read of a locked entry returns the stored entry.
- R4: A read of the one-step alias (word address 32+i) on a free entry locks it and returns lock=1, owner=`busMaster`, process=0.
- R5: A write with bit 31 clear releases a locked entry only when write bits 11:8 equal the stored owner and write bits 7:0 equal the stored process. On success the entry returns to all zero; otherwise it is unchanged.
- R6: A write to the bulk clear register (word 64) with key in bits 31:16 and owner in bits 11:8 frees every locked entry with that owner, provided the key equals the stored key. Entries of other owners stay locked, and a wrong key changes nothing.
- R7: The key register (word 65) stores write bits 31:16 and reads them back in bits 31:16, with the lower bits zero.
- R8: Core c has an enable register at word 72+4c and a status register at word 73+4c, bit i per semaphore. Freeing semaphore i, by single or bulk release, sets status bit i of each core whose enable bit i is 1. `irq[c]` is the OR of that core's enabled status bits.
- R9: Writing 1 to bit i of core c's clear register (word 74+4c) clears status bit i of that core. Zero bits leave status unchanged.
- R10: A read of an entry register (word i) never changes any semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 7 | Word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busMaster | input | 4 | Master ID of the current transaction |
| busRdata | output | 32 | Read data, one cycle after the read strobe |
| irq | output | 2 | Per-core interrupt, one bit per core |

## Verification
The bench builds the bank with its default size: 32 semaphores and two interrupt cores. At that size the whole address map is decoded, from entry 0 through the second core's clear register at word 78. The two cores get different enable masks, so one release must raise one `irq` line and leave the other low. A bulk release then has to hit both lines at once while it skips an entry held by a different master.

// File: rtl/semPkg.sv
package semPkg;
  localparam int CORE_W = 4;
  localparam int PROC_W = 8;

  typedef struct packed {
    logic              lock;
    logic [CORE_W-1:0] core;
    logic [PROC_W-1:0] proc;
  } semEntry_t;

  typedef struct packed {
    logic lockWr;
    logic unlockWr;
    logic mainRead;
    logic rlRead;
    logic bulkClr;
    logic keyWr;
    logic keyRead;
    logic ierWr;
    logic ierRead;
    logic isrRead;
    logic icrWr;
  } semStrb_t;

  function automatic logic [31:0] packEntry(semEntry_t e);
    return {e.lock, 19'b0, e.core, e.proc};
  endfunction
endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import semPkg::*;
#(
  parameter int NUM_SEM   = 32,
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 7,
  localparam int SEM_W    = $clog2(NUM_SEM),
  localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              lockBit,
  output semStrb_t          strb,
  output logic [SEM_W-1:0]  semIdx,
  output logic [CIDX_W-1:0] coreIdx
);
  localparam int RL_BASE  = NUM_SEM;
  localparam int CLR_ADDR = 2 * NUM_SEM;
  localparam int KEY_ADDR = CLR_ADDR + 1;
  localparam int IRQ_BASE = CLR_ADDR + 8;
  localparam int IRQ_END  = IRQ_BASE + 4 * NUM_CORES;

  logic              rdOnly;
  logic [ADDR_W-1:0] off;

  always_comb begin
    strb    = '0;
    semIdx  = '0;
    coreIdx = '0;
    off     = '0;
    rdOnly  = busRd && !busWr;
    if (busAddr < ADDR_W'(RL_BASE)) begin
      semIdx        = SEM_W'(busAddr);
      strb.lockWr   = busWr && lockBit;
      strb.unlockWr = busWr && !lockBit;
      strb.mainRead = rdOnly;
    end else if (busAddr < ADDR_W'(CLR_ADDR)) begin
      semIdx      = SEM_W'(busAddr - ADDR_W'(RL_BASE));
      strb.rlRead = rdOnly;
    end else if (busAddr == ADDR_W'(CLR_ADDR)) begin
      strb.bulkClr = busWr;
    end else if (busAddr == ADDR_W'(KEY_ADDR)) begin
      strb.keyWr   = busWr;
      strb.keyRead = rdOnly;
    end else if (busAddr >= ADDR_W'(IRQ_BASE) && busAddr < ADDR_W'(IRQ_END)) begin
      off     = busAddr - ADDR_W'(IRQ_BASE);
      coreIdx = CIDX_W'(off >> 2);
      case (off[1:0])
        2'd0: begin strb.ierWr = busWr; strb.ierRead = rdOnly; end
        2'd1: strb.isrRead = rdOnly;
        2'd2: strb.icrWr = busWr;
        default: ;
      endcase
    end
  end

  // at most one operation decoded per bus cycle (R2 decode)
  p_single_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
endmodule

// File: rtl/semDatapath.sv
module semDatapath
  import semPkg::*;
#(
  parameter int NUM_SEM   = 32,
  parameter int NUM_CORES = 2,
  localparam int SEM_W    = $clog2(NUM_SEM),
  localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  semStrb_t             strb,
  input  logic [SEM_W-1:0]     semIdx,
  input  logic [CIDX_W-1:0]    coreIdx,
  input  logic [31:0]          busWdata,
  input  logic [CORE_W-1:0]    busMaster,
  output logic [31:0]          busRdata,
  output logic [NUM_CORES-1:0] irq
);
  semEntry_t                 semTab [NUM_SEM];
  logic      [NUM_SEM-1:0]   freed;
  logic      [NUM_SEM-1:0]   lockVec;
  logic      [NUM_SEM-1:0]   ierTab [NUM_CORES];
  logic      [NUM_SEM-1:0]   isrTab [NUM_CORES];
  logic      [15:0]          clrKey;
  logic      [CORE_W-1:0]    wCore;
  logic      [PROC_W-1:0]    wProc;
  logic                      keyOk;
  semEntry_t                 cur;
  semEntry_t                 rlVal;
  logic      [31:0]          rdNext;

  assign wCore = busWdata[11:8];
  assign wProc = busWdata[7:0];
  assign keyOk = (busWdata[31:16] == clrKey);
  assign cur   = semTab[semIdx];

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    semEntry_t ent;
    logic hit, take, ownMatch, bulkHit;
    assign hit      = (semIdx == SEM_W'(i));
    assign take     = hit && !ent.lock && (strb.lockWr || strb.rlRead);
    assign ownMatch = (wCore == ent.core) && (wProc == ent.proc);
    assign bulkHit  = strb.bulkClr && keyOk && (ent.core == wCore);
    assign freed[i] = ent.lock && ((hit && strb.unlockWr && ownMatch) || bulkHit);
    assign lockVec[i] = ent.lock;
    assign semTab[i]  = ent;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ent <= '0;
      else if (take)     ent <= {1'b1, busMaster, strb.lockWr ? wProc : PROC_W'(0)};
      else if (freed[i]) ent <= '0;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_SEM-1:0] ier, isr, clrMask;
    logic sel;
    assign sel     = (coreIdx == CIDX_W'(c));
    assign clrMask = (strb.icrWr && sel) ? busWdata[NUM_SEM-1:0] : '0;
    assign ierTab[c] = ier;
    assign isrTab[c] = isr;
    assign irq[c]    = |(isr & ier);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ier <= '0;
        isr <= '0;
      end else begin
        if (strb.ierWr && sel) ier <= busWdata[NUM_SEM-1:0];
        isr <= (isr & ~clrMask) | (freed & ier);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 clrKey <= '0;
    else if (strb.keyWr)        clrKey <= busWdata[31:16];
  end

  assign rlVal = cur.lock ? cur : {1'b1, busMaster, PROC_W'(0)};

  always_comb begin
    rdNext = '0;
    if (strb.mainRead)     rdNext = packEntry(cur);
    else if (strb.rlRead)  rdNext = packEntry(rlVal);
    else if (strb.keyRead) rdNext = {clrKey, 16'b0};
    else if (strb.ierRead) rdNext = 32'(ierTab[coreIdx]);
    else if (strb.isrRead) rdNext = 32'(isrTab[coreIdx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busRdata <= '0;
    else if (strb.mainRead || strb.rlRead || strb.keyRead || strb.ierRead || strb.isrRead)
      busRdata <= rdNext;
  end

  p_owner_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb.lockWr || strb.rlRead) && cur.lock) |=> semTab[$past(semIdx)] == $past(cur));

  p_bad_unlock_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.unlockWr && cur.lock && (wCore != cur.core || wProc != cur.proc))
      |=> semTab[$past(semIdx)].lock);

  p_bad_key_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.bulkClr && busWdata[31:16] != clrKey) |=> $stable(lockVec));

  p_status_raised_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.unlockWr && freed[semIdx] && ierTab[0][semIdx]) |=> isrTab[0][$past(semIdx)]);

  p_read_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.mainRead |=> $stable(lockVec));
endmodule

// File: rtl/semBank.sv
module semBank
  import semPkg::*;
#(
  parameter int NUM_SEM   = 32,
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 7,
  localparam int SEM_W    = $clog2(NUM_SEM),
  localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [31:0]          busWdata,
  input  logic [3:0]           busMaster,
  output logic [31:0]          busRdata,
  output logic [NUM_CORES-1:0] irq
);
  semStrb_t          strb;
  logic [SEM_W-1:0]  semIdx;
  logic [CIDX_W-1:0] coreIdx;

  semCtrl #(.NUM_SEM(NUM_SEM), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .lockBit(busWdata[31]), .strb(strb), .semIdx(semIdx), .coreIdx(coreIdx));

  semDatapath #(.NUM_SEM(NUM_SEM), .NUM_CORES(NUM_CORES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .semIdx(semIdx), .coreIdx(coreIdx),
    .busWdata(busWdata), .busMaster(busMaster), .busRdata(busRdata), .irq(irq));
endmodule

// File: tb/tb_semBank.sv
module tb_semBank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  busAddr = '0;
  logic        busWr = 0, busRd = 0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busMaster = '0;
  logic [31:0] busRdata;
  logic [1:0]  irq;

  int errCnt = 0, chkCnt = 0;
  bit done = 0, monArm = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  localparam logic [3:0] PRI = 4'd3, COP = 4'd1;

  always #2.5 clk = ~clk;

  semBank dut (.clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busMaster(busMaster), .busRdata(busRdata), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [6:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    busAddr = a; busWdata = d; busMaster = m; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic busRead(input logic [6:0] a, input logic [3:0] m, input logic [31:0] e, input string tag);
    @(negedge clk);
    busAddr = a; busMaster = m; busRd = 1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    busRd = 0;
  endtask

  // monitor: a read strobe seen at an edge is compared at the next falling edge
  always @(posedge clk) monArm <= busRd && !busWr;
  always @(negedge clk) begin
    if (monArm) begin
      if (expQ.size() == 0) check("scoreboard underrun", 32'd1, 32'd0);
      else check(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    busRead(7'd0, PRI, 32'h0, "R1 entry0 after reset");
    busRead(7'd65, PRI, 32'h0, "R1 key after reset");
    busRead(7'd73, PRI, 32'h0, "R1 status core0 after reset");
    check("R1 irq after reset", 32'(irq), 32'h0);

    busWrite(7'd72, 32'hFFFF_FFFF, PRI);
    busWrite(7'd76, 32'h0000_0001, PRI);
    busRead(7'd76, PRI, 32'h1, "R8 enable core1 readback");

    // R2 two-step lock
    busWrite(7'd5, 32'h8000_002A, PRI);
    busRead(7'd5, PRI, 32'h8000_032A, "R2 two-step lock entry5");
    // R3 lock attempts on locked entry
    busWrite(7'd5, 32'h8000_0011, COP);
    busRead(7'd5, COP, 32'h8000_032A, "R3 lock write on locked keeps owner");
    busRead(7'd37, COP, 32'h8000_032A, "R3 one-step read of locked returns owner");
    busRead(7'd5, COP, 32'h8000_032A, "R3 owner unchanged after one-step");
    // R4 one-step lock
    busRead(7'd39, COP, 32'h8000_0100, "R4 one-step lock entry7");
    busRead(7'd7, COP, 32'h8000_0100, "R4 entry7 stored");
    // R5 bad unlocks
    busWrite(7'd5, 32'h0000_032B, PRI);
    busRead(7'd5, PRI, 32'h8000_032A, "R5 wrong process keeps lock");
    busWrite(7'd5, 32'h0000_012A, COP);
    busRead(7'd5, PRI, 32'h8000_032A, "R5 wrong owner keeps lock");
    busRead(7'd73, PRI, 32'h0, "R8 no status on failed unlock");
    // R5 good unlock, R8 status
    busWrite(7'd5, 32'h0000_032A, PRI);
    busRead(7'd5, PRI, 32'h0, "R5 matching unlock frees");
    busRead(7'd73, PRI, 32'h0000_0020, "R8 status core0 bit5");
    busRead(7'd77, PRI, 32'h0, "R8 core1 not enabled for bit5");
    check("R8 irq after single unlock", 32'(irq), 32'h1);
    // R9 clear status
    busWrite(7'd74, 32'h0000_0000, PRI);
    busRead(7'd73, PRI, 32'h0000_0020, "R9 zero clear keeps status");
    busWrite(7'd74, 32'h0000_0020, PRI);
    busRead(7'd73, PRI, 32'h0, "R9 status cleared");
    check("R9 irq after clear", 32'(irq), 32'h0);
    // R7 key
    busWrite(7'd65, 32'hBEEF_1234, PRI);
    busRead(7'd65, PRI, 32'hBEEF_0000, "R7 key readback");
    // R6 bulk unlock
    busWrite(7'd0, 32'h8000_0001, PRI);
    busWrite(7'd1, 32'h8000_0002, PRI);
    busRead(7'd34, COP, 32'h8000_0100, "R4 one-step lock entry2");
    busWrite(7'd64, 32'h1234_0300, PRI);
    busRead(7'd0, PRI, 32'h8000_0301, "R6 wrong key no effect");
    busRead(7'd73, PRI, 32'h0, "R6 wrong key no status");
    busWrite(7'd64, 32'hBEEF_0300, PRI);
    busRead(7'd0, PRI, 32'h0, "R6 bulk frees entry0");
    busRead(7'd1, PRI, 32'h0, "R6 bulk frees entry1");
    busRead(7'd2, PRI, 32'h8000_0100, "R6 other owner entry2 kept");
    busRead(7'd7, PRI, 32'h8000_0100, "R6 other owner entry7 kept");
    busRead(7'd73, PRI, 32'h0000_0003, "R8 bulk status core0");
    busRead(7'd77, PRI, 32'h0000_0001, "R8 bulk status core1");
    check("R8 irq after bulk", 32'(irq), 32'h3);
    busWrite(7'd74, 32'h0000_0003, PRI);
    busWrite(7'd78, 32'h0000_0001, PRI);
    check("R9 irq after both clears", 32'(irq), 32'h0);
    // R4 reclaim, R10 read no side effect
    busRead(7'd32, PRI, 32'h8000_0300, "R4 one-step reclaim entry0");
    busRead(7'd9, PRI, 32'h0, "R10 read of free entry9");
    busRead(7'd9, PRI, 32'h0, "R10 entry9 still free");
    busRead(7'd41, COP, 32'h8000_0100, "R10 entry9 free for one-step");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(expQ.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule